// File: doc/BRIEF.md
# DMA Page-Boundary Segment Splitter

This block takes a block-transfer request and turns it into one or two DMA segments, none of which crosses a 64 KiB physical page. A request gives a sector count, a direction bit and a 20-bit physical start address, made of a 4-bit page and a 16-bit offset. The block converts sectors to bytes (512 bytes each) and decides whether the span fits in what is left of the current page. If it does not fit, the block cuts the span at the page end.

Segments leave one at a time on a valid/ready handshake. Each segment carries its page, offset, byte length, direction and a last flag. After each accepted segment the running address moves forward by the segment length. A carry out of the offset increments the page. The running address is visible on `cur_page`/`cur_offset`, so after `done` it shows the first address past the transfer.

A controller in front of a DMA engine uses it like this: present a request, program the engine from each segment as it appears, then wait for `done`. Requests with an illegal sector count raise `err` and produce no segment.

The control state machine has five states:
- **IDLE** accepts a request. IDLE→SEG_A on a legal request. IDLE→REJ on an illegal one.
- **SEG_A** presents the first (or only) segment. SEG_A→SEG_B when it is accepted and a split is needed. SEG_A→FIN when it is accepted and no split is needed.
- **SEG_B** presents the remainder at offset zero of the next page. SEG_B→FIN on acceptance.
- **FIN** pulses `done`, then goes back to IDLE.
- **REJ** pulses `err`, then goes back to IDLE.

Top module: `dma_page_splitter`

## Requirements
- R1: A legal request of S sectors moves S×512 bytes in total, and every segment length is nonzero.
- R2: When the start offset is 0, exactly one segment is issued, with length S×512, the request's page and offset, and `seg_last`=1.
- R3: When the offset is nonzero and S×512 ≤ 65536−offset, exactly one segment is issued, with length S×512 and `seg_last`=1.
- R4: Otherwise two segments are issued. The first sits at the request address with length 65536−offset and `seg_last`=0. The second sits at offset 0 of page+1 (modulo 16), with the rest of the bytes and `seg_last`=1.
- R5: No segment spans past the end of its 64 KiB page, so offset+length ≤ 65536.
- R6: Each time a segment is accepted, `cur_offset` grows by its length modulo 65536. A carry out of bit 15 adds 1 to `cur_page`, modulo 16. After `done`, `cur_page`/`cur_offset` equal the start address plus S×512.
- R7: A request with S = 0 or S > 64 gives a one-cycle `err` pulse in the cycle after acceptance. It issues no segment, raises no `done`, and leaves `cur_page`/`cur_offset` unchanged.
- R8: A presented segment holds `seg_valid` and all its fields stable until `seg_ready` is sampled high. The second segment appears only after the first has been accepted.
- R9: `done` is high for exactly one cycle, the cycle after the last segment is accepted.
- R10: `req_ready` is high only in IDLE, never while a segment is presented, and every segment carries the request's direction on `seg_dir`.
- R11: After reset: `req_ready`=1, `seg_valid`=0, `done`=0, `err`=0, and `cur_page`/`cur_offset` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request (IDLE) |
| req_sectors | input | 8 | Request size in 512-byte sectors |
| req_dir | input | 1 | Transfer direction, passed through |
| req_page | input | 4 | Start address bits 19..16 |
| req_offset | input | 16 | Start address bits 15..0 |
| seg_valid | output | 1 | Segment present |
| seg_ready | input | 1 | Segment accepted when high with seg_valid |
| seg_page | output | 4 | Segment page |
| seg_offset | output | 16 | Segment start offset |
| seg_len | output | 17 | Segment length in bytes (1..65536) |
| seg_dir | output | 1 | Segment direction |
| seg_last | output | 1 | Final segment of the request |
| cur_page | output | 4 | Running page (advanced after each segment) |
| cur_offset | output | 16 | Running offset (advanced after each segment) |
| done | output | 1 | One-cycle pulse after the last segment |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The assertions assume the request fields are steady during the cycle in which `req_valid` is sampled. They also assume `seg_ready` is a plain level that may stay low for any number of cycles. The bench drives every field at the falling edge and removes `req_valid` right after the one rising edge that accepts it. The sweep covers every sector count from 0 to 66. It crosses those counts with offsets around page ends (0, 1, 0x7FFF, 0x8000, 0xC001, 0xFE00, 0xFFFF and others), pages that include 15 so the page wrap is exercised, and a holding delay of zero to two cycles on `seg_ready`.

// File: rtl/dps_pkg.sv
package dps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEG_A,
        ST_SEG_B,
        ST_FIN,
        ST_REJ
    } dps_state_e;

endpackage

// File: rtl/dps_size_calc.sv
module dps_size_calc #(
    parameter int SECT_W     = 8,
    parameter int OFF_W      = 16,
    parameter int SECT_SHIFT = 9,
    parameter int MAX_SECT   = 64,
    localparam int LEN_W     = OFF_W + 1
) (
    input  logic [SECT_W-1:0] sectors,
    input  logic [OFF_W-1:0]  offset,
    output logic              legal,
    output logic [LEN_W-1:0]  total_bytes,
    output logic              split,
    output logic [LEN_W-1:0]  first_len,
    output logic [LEN_W-1:0]  second_len
);
    localparam logic [LEN_W-1:0] PAGE_BYTES = LEN_W'(1) << OFF_W;

    logic [LEN_W-1:0] room;

    always_comb begin
        legal       = (sectors != '0) && (sectors <= SECT_W'(MAX_SECT));
        total_bytes = LEN_W'(sectors) << SECT_SHIFT;
        room        = PAGE_BYTES - {1'b0, offset};
        split       = (offset != '0) && (total_bytes > room);
        first_len   = split ? room : total_bytes;
        second_len  = total_bytes - room;
    end

endmodule

// File: rtl/dps_addr_step.sv
module dps_addr_step #(
    parameter int PAGE_W = 4,
    parameter int OFF_W  = 16,
    localparam int LEN_W = OFF_W + 1
) (
    input  logic [PAGE_W-1:0] page_in,
    input  logic [OFF_W-1:0]  off_in,
    input  logic [LEN_W-1:0]  len,
    output logic [PAGE_W-1:0] page_out,
    output logic [OFF_W-1:0]  off_out
);
    logic [LEN_W-1:0] sum;

    always_comb begin
        sum      = {1'b0, off_in} + len;
        off_out  = sum[OFF_W-1:0];
        page_out = page_in + PAGE_W'(sum[OFF_W]);
    end

endmodule

// File: rtl/dps_ctrl.sv
module dps_ctrl
    import dps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_legal,
    input  logic split,
    input  logic seg_ready,
    output logic req_ready,
    output logic load,
    output logic seg_valid,
    output logic seg_second,
    output logic advance,
    output logic done,
    output logic err
);
    dps_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req_valid) nxt = req_legal ? ST_SEG_A : ST_REJ;
            ST_SEG_A: if (seg_ready) nxt = split ? ST_SEG_B : ST_FIN;
            ST_SEG_B: if (seg_ready) nxt = ST_FIN;
            ST_FIN:   nxt = ST_IDLE;
            ST_REJ:   nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready  = 1'b0;
        load       = 1'b0;
        seg_valid  = 1'b0;
        seg_second = 1'b0;
        done       = 1'b0;
        err        = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                load      = req_valid && req_legal;
            end
            ST_SEG_A: seg_valid = 1'b1;
            ST_SEG_B: begin
                seg_valid  = 1'b1;
                seg_second = 1'b1;
            end
            ST_FIN:  done = 1'b1;
            ST_REJ:  err  = 1'b1;
            default: ;
        endcase
        advance = seg_valid && seg_ready;
    end

    // R9: done never lasts two cycles
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: err is a single pulse followed by readiness
    a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (!err && req_ready));
    // R8: second segment only after the first was accepted
    a_r8_second_after_first: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !seg_second) && seg_ready && split |=> seg_second);
    // R8: an unaccepted segment stays presented
    a_r8_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_second)));

endmodule

// File: rtl/dma_page_splitter.sv
module dma_page_splitter #(
    parameter int SECT_W     = 8,
    parameter int PAGE_W     = 4,
    parameter int OFF_W      = 16,
    parameter int SECT_SHIFT = 9,
    parameter int MAX_SECT   = 64,
    localparam int LEN_W     = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SECT_W-1:0] req_sectors,
    input  logic              req_dir,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [OFF_W-1:0]  req_offset,
    output logic              seg_valid,
    input  logic              seg_ready,
    output logic [PAGE_W-1:0] seg_page,
    output logic [OFF_W-1:0]  seg_offset,
    output logic [LEN_W-1:0]  seg_len,
    output logic              seg_dir,
    output logic              seg_last,
    output logic [PAGE_W-1:0] cur_page,
    output logic [OFF_W-1:0]  cur_offset,
    output logic              done,
    output logic              err
);
    localparam logic [LEN_W:0] PAGE_SPAN = (LEN_W+1)'(1) << OFF_W;

    logic             legal_c, split_c, load, advance, seg_second;
    logic [LEN_W-1:0] total_c, first_c, second_c;
    logic [PAGE_W-1:0] page_r, page_nx;
    logic [OFF_W-1:0]  off_r, off_nx;
    logic [LEN_W-1:0]  first_r, second_r;
    logic              split_r, dir_r;

    dps_size_calc #(
        .SECT_W(SECT_W), .OFF_W(OFF_W), .SECT_SHIFT(SECT_SHIFT), .MAX_SECT(MAX_SECT)
    ) u_size (
        .sectors(req_sectors), .offset(req_offset), .legal(legal_c),
        .total_bytes(total_c), .split(split_c),
        .first_len(first_c), .second_len(second_c)
    );

    dps_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_legal(legal_c),
        .split(split_r), .seg_ready(seg_ready), .req_ready(req_ready),
        .load(load), .seg_valid(seg_valid), .seg_second(seg_second),
        .advance(advance), .done(done), .err(err)
    );

    dps_addr_step #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_step (
        .page_in(page_r), .off_in(off_r), .len(seg_len),
        .page_out(page_nx), .off_out(off_nx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_r   <= '0;
            off_r    <= '0;
            first_r  <= '0;
            second_r <= '0;
            split_r  <= 1'b0;
            dir_r    <= 1'b0;
        end else if (load) begin
            page_r   <= req_page;
            off_r    <= req_offset;
            first_r  <= first_c;
            second_r <= second_c;
            split_r  <= split_c;
            dir_r    <= req_dir;
        end else if (advance) begin
            page_r   <= page_nx;
            off_r    <= off_nx;
        end
    end

    always_comb begin
        seg_page   = page_r;
        seg_offset = off_r;
        seg_len    = seg_second ? second_r : first_r;
        seg_dir    = dir_r;
        seg_last   = seg_second || !split_r;
        cur_page   = page_r;
        cur_offset = off_r;
    end

    // R5: a segment never runs past its page end
    a_r5_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> ((LEN_W+1)'(seg_offset) + (LEN_W+1)'(seg_len)) <= PAGE_SPAN);
    // R1: no empty segment
    a_r1_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> seg_len != '0);
    // R4: the remainder starts at a page base
    a_r4_second_at_base: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && seg_second) |-> seg_offset == '0);
    // R8: fields hold while the segment waits
    a_r8_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !seg_ready) |=> ($stable(seg_offset) && $stable(seg_len) && $stable(seg_page)));
    // R10: no request taken while a segment is out
    a_r10_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !seg_valid);
    // R9: done follows acceptance of the last segment
    a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && seg_ready && seg_last) |=> done);
    // R7: a rejection never coincides with a segment or completion
    a_r7_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!seg_valid && !done));

endmodule

// File: tb/test_dma_page_splitter.sv
module test_dma_page_splitter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_dir = 1'b0, seg_ready = 1'b0;
    logic [7:0]  req_sectors = '0;
    logic [3:0]  req_page = '0;
    logic [15:0] req_offset = '0;
    logic        req_ready, seg_valid, seg_dir, seg_last, done, err;
    logic [3:0]  seg_page, cur_page;
    logic [15:0] seg_offset, cur_offset;
    logic [16:0] seg_len;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit finished = 1'b0;
    int end_page = 0, end_off = 0;

    always #4 clk = ~clk;

    dma_page_splitter i_dma_page_splitter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_sectors(req_sectors), .req_dir(req_dir), .req_page(req_page),
        .req_offset(req_offset), .seg_valid(seg_valid), .seg_ready(seg_ready),
        .seg_page(seg_page), .seg_offset(seg_offset), .seg_len(seg_len),
        .seg_dir(seg_dir), .seg_last(seg_last), .cur_page(cur_page),
        .cur_offset(cur_offset), .done(done), .err(err)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            summary();
        end
    end

    // Present one segment check, hold it for 'hold' cycles, then accept it.
    task automatic take_seg(input int pg, input int off, input int len,
                            input int last, input int dir, input int hold);
        for (int h = 0; h <= hold; h++) begin
            chk("R8 seg_valid", int'(seg_valid), 1);
            chk("R4 seg_page", int'(seg_page), pg);
            chk("R4 seg_offset", int'(seg_offset), off);
            chk("R1 seg_len", int'(seg_len), len);
            chk("R2 seg_last", int'(seg_last), last);
            chk("R10 seg_dir", int'(seg_dir), dir);
            chk("R10 req_ready busy", int'(req_ready), 0);
            chk("R9 no early done", int'(done), 0);
            if (h == hold) seg_ready = 1'b1;
            @(negedge clk);
        end
        seg_ready = 1'b0;
    endtask

    task automatic run_req(input int s, input int dir, input int pg, input int off, input int hold);
        int bytes, room, tot;
        bit legal, split;
        bytes = s * 512;
        room  = 65536 - off;
        legal = (s != 0) && (s <= 64);
        split = (off != 0) && (bytes > room);
        chk("R10 req_ready idle", int'(req_ready), 1);
        req_valid   = 1'b1;
        req_sectors = 8'(s);
        req_dir     = dir[0];
        req_page    = 4'(pg);
        req_offset  = 16'(off);
        @(negedge clk);
        req_valid = 1'b0;
        if (!legal) begin
            chk("R7 err pulse", int'(err), 1);
            chk("R7 no segment", int'(seg_valid), 0);
            chk("R7 no done", int'(done), 0);
            @(negedge clk);
            chk("R7 err cleared", int'(err), 0);
            chk("R7 page kept", int'(cur_page), end_page);
            chk("R7 offset kept", int'(cur_offset), end_off);
        end else begin
            if (split) begin
                take_seg(pg, off, room, 0, dir, hold);
                chk("R8 second follows", int'(done), 0);
                take_seg((pg + 1) % 16, 0, bytes - room, 1, dir, (hold + 1) % 3);
            end else begin
                take_seg(pg, off, bytes, 1, dir, hold);
            end
            tot = off + bytes;
            end_off  = tot % 65536;
            end_page = (pg + tot / 65536) % 16;
            chk("R9 done pulse", int'(done), 1);
            chk("R6 end page", int'(cur_page), end_page);
            chk("R6 end offset", int'(cur_offset), end_off);
            @(negedge clk);
            chk("R9 done single", int'(done), 0);
        end
    endtask

    int offs[12] = '{0, 1, 2, 511, 512, 32767, 32768, 49153, 65024, 65535, 32256, 4660};

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 req_ready", int'(req_ready), 1);
        chk("R11 seg_valid", int'(seg_valid), 0);
        chk("R11 done", int'(done), 0);
        chk("R11 err", int'(err), 0);
        chk("R11 cur_page", int'(cur_page), 0);
        chk("R11 cur_offset", int'(cur_offset), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int oi = 0; oi < 12; oi++) begin
            for (int s = 0; s <= 66; s++) begin
                run_req(s, s % 2, (oi * 5 + s) % 16 == 0 ? 15 : (oi * 5 + s) % 16,
                        offs[oi], (s + oi) % 3);
            end
        end
        // R3/R4 boundaries: exact fit versus one byte over, at page 15 (wrap)
        run_req(64, 1, 15, 32768, 0);
        run_req(64, 0, 15, 32769, 1);
        run_req(255, 1, 3, 100, 0);
        summary();
    end

endmodule